// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block turns an externally generated time-base count into two pulse-width modulated levels, A and B. It holds two compare values, one per compare unit. Each compare unit can take a new value at once or hold it in a shadow copy until a chosen counter event. Each cycle, three events can occur: the zero strobe, the count equalling compare A while counting up, and the count equalling compare B while counting up. A per-output action word gives a 2-bit reaction to each event. A continuous software force can pin either output to a fixed level.

A time-base counter outside the block supplies the count, the direction and the zero and period strobes on every clock. Software or a sequencer supplies the compare values with write strobes, the compare configuration, the two action words and the force word. Both outputs are registered, so each one changes on the clock edge that ends the cycle in which its event was seen.

Top module: `pwm_aq_top`

## Requirements
- R1: While reset is asserted and right after it, both outputs are low and both compare values and their shadow copies are zero.
- R2: An action code is 2 bits: 0 does nothing, 1 drives low, 2 drives high, 3 inverts the current level. The chosen action takes effect on the clock edge that ends the event's cycle. With no event and no force, an output holds its level.
- R3: Each output has its own 16-bit action word. The zero action is in bits 1:0, the compare-A-up action in bits 5:4 and the compare-B-up action in bits 9:8. Either output may react to either compare.
- R4: A compare event occurs only when the count equals the active compare value while the up flag is 1. An equal count with the up flag at 0 causes no action.
- R5: When several events occur in one cycle, only the highest-priority event whose action is not 0 is applied. Compare B outranks compare A, and compare A outranks zero.
- R6: A compare unit in immediate mode (mode bit 0) copies a written value into the active compare on the write's clock edge. The compare event therefore uses the new value from the next cycle onward.
- R7: In shadow mode (mode bit 1) a write goes only to the shadow copy. The copy moves to the active compare in a cycle whose load select matches: 0 = zero strobe, 1 = period strobe, 2 = either strobe, 3 = never. In the compare configuration word, A's mode is bit 4 and its select bits 1:0; B's mode is bit 6 and its select bits 3:2.
- R8: The force word holds a 2-bit code per output, A in bits 1:0 and B in bits 3:2. Code 1 forces low and code 2 forces high, both from the next clock and over any event. Codes 0 and 3 release the output, which then keeps the forced level until an event acts on it.
- R9: Over one period of counts 0 to 9, with zero at count 0 and compare value C, the output is high for C of every 10 cycles when set at zero and cleared at compare A. It is high for 10 - C when cleared at zero and set at compare A. A compare value of 0 gives a constant low or a constant high with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_cnt | input | CNT_W | Time-base count |
| evt_zero | input | 1 | Count-reached-zero strobe |
| evt_period | input | 1 | Count-reached-period strobe |
| cnt_up | input | 1 | 1 while the counter counts up |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_val | input | CNT_W | Value written to compare A |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_val | input | CNT_W | Value written to compare B |
| cmp_cfg | input | 16 | Compare modes and shadow load selects |
| act_cfg_a | input | 16 | Event actions for output A |
| act_cfg_b | input | 16 | Event actions for output B |
| sw_force | input | 4 | Continuous force codes for A and B |
| pwm_a | output | 1 | Output level A |
| pwm_b | output | 1 | Output level B |

## Verification
The bench builds the block with its default count width of 16 bits. It uses small compare values and a short period of ten counts, so every load select, every action code and every event collision can be reached within a handful of cycles. Compare values of 0 and 4 over whole periods bring both duty extremes and a middle duty within reach. Setting both compares to one value makes the compare-B-over-compare-A ordering observable at the outputs.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    // 2-bit reaction to a counter event
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    // when a shadow copy moves into the active compare
    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PERIOD = 2'd1,
        LD_EITHER = 2'd2,
        LD_FROZEN = 2'd3
    } load_e;

    // continuous software force per output
    typedef enum logic [1:0] {
        FRC_OFF  = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2,
        FRC_RSVD = 2'd3
    } force_e;

    localparam int CTL_W   = 16;
    localparam int NUM_OUT = 2;
    localparam int FRC_W   = 2 * NUM_OUT;

    // action word field offsets (decoded by the channel logic)
    localparam int ZRO_LSB = 0;
    localparam int CAU_LSB = 4;
    localparam int CBU_LSB = 8;

    // compare configuration field offsets
    localparam int LDA_LSB = 0;
    localparam int LDB_LSB = 2;
    localparam int SHA_BIT = 4;
    localparam int SHB_BIT = 6;

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shadow_mode,
    input  logic [1:0]       load_sel,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             zero_evt,
    input  logic             prd_evt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] cnt,
    output logic             up_match
);

    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] shadow;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    load_now;

    always_comb begin
        st_d = st_q;
        case (load_e'(load_sel))
            LD_ZERO:   load_now = zero_evt;
            LD_PERIOD: load_now = prd_evt;
            LD_EITHER: load_now = zero_evt | prd_evt;
            default:   load_now = 1'b0;
        endcase
        if (shadow_mode) begin
            if (load_now) st_d.active = st_q.shadow;
            if (wr_en)    st_d.shadow = wr_val;
        end else if (wr_en) begin
            st_d.active = wr_val;
            st_d.shadow = wr_val;
        end
        up_match = dir_up && (cnt == st_q.active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // immediate write reaches the active compare on its own edge
    p_imm_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !shadow_mode) |=> (st_q.active == $past(wr_val)));

    // frozen shadow never disturbs the active compare
    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_mode && load_sel == 2'd3) |=> $stable(st_q.active));

    // shadowed unit without any strobe keeps its active compare
    p_no_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_mode && !zero_evt && !prd_evt) |=> $stable(st_q.active));

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] act_zero,
    input  logic [1:0] act_ca,
    input  logic [1:0] act_cb,
    input  logic [1:0] force_code,
    input  logic       zero_evt,
    input  logic       ca_match,
    input  logic       cb_match,
    output logic       level
);

    typedef struct packed {
        logic lvl;
    } ch_st_t;

    ch_st_t st_d, st_q;
    act_e   pick;

    always_comb begin
        st_d = st_q;
        // lowest priority first, higher ones overwrite
        pick = ACT_NONE;
        if (zero_evt && act_e'(act_zero) != ACT_NONE) pick = act_e'(act_zero);
        if (ca_match && act_e'(act_ca)   != ACT_NONE) pick = act_e'(act_ca);
        if (cb_match && act_e'(act_cb)   != ACT_NONE) pick = act_e'(act_cb);
        case (force_e'(force_code))
            FRC_LOW:  st_d.lvl = 1'b0;
            FRC_HIGH: st_d.lvl = 1'b1;
            default:  st_d.lvl = apply_act(pick, st_q.lvl);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_code == 2'd1) |=> !level);

    p_force_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_code == 2'd2) |=> level);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_evt && !ca_match && !cb_match && force_code != 2'd1 && force_code != 2'd2)
        |=> $stable(level));

    p_cmp_beats_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && act_zero == 2'd2 && ca_match && act_ca == 2'd1 && !cb_match
         && force_code != 2'd1 && force_code != 2'd2) |=> !level);

endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_cnt,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic             cnt_up,
    input  logic             cmpa_wr,
    input  logic [CNT_W-1:0] cmpa_val,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmpb_val,
    input  logic [CTL_W-1:0] cmp_cfg,
    input  logic [CTL_W-1:0] act_cfg_a,
    input  logic [CTL_W-1:0] act_cfg_b,
    input  logic [FRC_W-1:0] sw_force,
    output logic             pwm_a,
    output logic             pwm_b
);

    logic [NUM_OUT-1:0] wr_v;
    logic [CNT_W-1:0]   val_v [NUM_OUT];
    logic [CTL_W-1:0]   act_v [NUM_OUT];
    logic [NUM_OUT-1:0] match_up;
    logic [NUM_OUT-1:0] pwm_v;
    logic               ctl_unused;

    assign wr_v     = {cmpb_wr, cmpa_wr};
    assign val_v[0] = cmpa_val;
    assign val_v[1] = cmpb_val;
    assign act_v[0] = act_cfg_a;
    assign act_v[1] = act_cfg_b;

    assign ctl_unused = ^{cmp_cfg[CTL_W-1:SHB_BIT+1], cmp_cfg[SHA_BIT+1],
                          act_cfg_a[CTL_W-1:CBU_LSB+2], act_cfg_a[CAU_LSB+3:CAU_LSB+2],
                          act_cfg_a[ZRO_LSB+3:ZRO_LSB+2],
                          act_cfg_b[CTL_W-1:CBU_LSB+2], act_cfg_b[CAU_LSB+3:CAU_LSB+2],
                          act_cfg_b[ZRO_LSB+3:ZRO_LSB+2]};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_cmp
        localparam int MB = (g == 0) ? SHA_BIT : SHB_BIT;
        localparam int SL = (g == 0) ? LDA_LSB : LDB_LSB;
        pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .shadow_mode (cmp_cfg[MB]),
            .load_sel    (cmp_cfg[SL +: 2]),
            .wr_en       (wr_v[g]),
            .wr_val      (val_v[g]),
            .zero_evt    (evt_zero),
            .prd_evt     (evt_period),
            .dir_up      (cnt_up),
            .cnt         (tb_cnt),
            .up_match    (match_up[g])
        );
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
        pwm_aq_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_zero   (act_v[g][ZRO_LSB +: 2]),
            .act_ca     (act_v[g][CAU_LSB +: 2]),
            .act_cb     (act_v[g][CBU_LSB +: 2]),
            .force_code (sw_force[2*g +: 2]),
            .zero_evt   (evt_zero),
            .ca_match   (match_up[0]),
            .cb_match   (match_up[1]),
            .level      (pwm_v[g])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

    // compare B outranks compare A on a shared output
    p_cb_beats_ca_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_up[0] && match_up[1] && act_cfg_a[CAU_LSB +: 2] == 2'd2
         && act_cfg_a[CBU_LSB +: 2] == 2'd1 && sw_force[1:0] != 2'd1
         && sw_force[1:0] != 2'd2) |=> !pwm_a);

    // a down-counting cycle with no zero strobe and no force leaves A alone
    p_down_no_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_up && !evt_zero && sw_force[1:0] != 2'd1 && sw_force[1:0] != 2'd2)
        |=> $stable(pwm_a));

endmodule

// File: tb/pwm_aq_top_bench.sv
`timescale 1ns/1ps
module pwm_aq_top_bench;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] tb_cnt = '0;
    logic             evt_zero = 1'b0, evt_period = 1'b0, cnt_up = 1'b0;
    logic             cmpa_wr = 1'b0, cmpb_wr = 1'b0;
    logic [CNT_W-1:0] cmpa_val = '0, cmpb_val = '0;
    logic [15:0]      cmp_cfg = '0, act_cfg_a = '0, act_cfg_b = '0;
    logic [3:0]       sw_force = '0;
    logic             pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_aq_top #(.CNT_W(CNT_W)) u_pwm_aq_top (
        .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .evt_zero(evt_zero),
        .evt_period(evt_period), .cnt_up(cnt_up), .cmpa_wr(cmpa_wr),
        .cmpa_val(cmpa_val), .cmpb_wr(cmpb_wr), .cmpb_val(cmpb_val),
        .cmp_cfg(cmp_cfg), .act_cfg_a(act_cfg_a), .act_cfg_b(act_cfg_b),
        .sw_force(sw_force), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct packed {
        logic        z;
        logic        p;
        logic        up;
        logic [15:0] cnt;
        logic [15:0] aa;
        logic [15:0] ab;
        logic [3:0]  frc;
        logic        ea;
        logic        eb;
    } vec_t;

    // compare A = 3, compare B = 5, both immediate; state starts at (0,0)
    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b0,1'b1,16'd0,16'h0012,16'h0102,4'h0,1'b1,1'b1}, // R2 R3 zero sets
        '{1'b0,1'b0,1'b1,16'd1,16'h0012,16'h0102,4'h0,1'b1,1'b1}, // R2 hold
        '{1'b0,1'b0,1'b1,16'd3,16'h0012,16'h0102,4'h0,1'b0,1'b1}, // R3 CA clears A
        '{1'b0,1'b0,1'b1,16'd5,16'h0012,16'h0102,4'h0,1'b0,1'b0}, // R3 CB clears B
        '{1'b0,1'b1,1'b1,16'd5,16'h0012,16'h0102,4'h0,1'b0,1'b0}, // R2 clear on low
        '{1'b1,1'b0,1'b1,16'd0,16'h0012,16'h0102,4'h0,1'b1,1'b1}, // R2
        '{1'b0,1'b0,1'b0,16'd3,16'h0012,16'h0102,4'h0,1'b1,1'b1}, // R4 down: no CA
        '{1'b0,1'b0,1'b1,16'd3,16'h0030,16'h0102,4'h0,1'b0,1'b1}, // R2 toggle
        '{1'b0,1'b0,1'b1,16'd3,16'h0030,16'h0102,4'h0,1'b1,1'b1}, // R2 toggle back
        '{1'b1,1'b0,1'b1,16'd3,16'h0012,16'h0102,4'h0,1'b0,1'b1}, // R5 CA over zero
        '{1'b0,1'b0,1'b1,16'd3,16'h0012,16'h0102,4'h6,1'b1,1'b0}, // R8 force A hi, B lo
        '{1'b1,1'b0,1'b1,16'd0,16'h0012,16'h0102,4'h6,1'b1,1'b0}, // R8 force beats zero
        '{1'b0,1'b0,1'b1,16'd1,16'h0012,16'h0102,4'h0,1'b1,1'b0}, // R8 release holds
        '{1'b1,1'b0,1'b1,16'd0,16'h0012,16'h0102,4'hF,1'b1,1'b1}, // R8 code 3 = none
        '{1'b1,1'b0,1'b1,16'd0,16'h0003,16'h0001,4'h0,1'b0,1'b0}, // R3 zero field 1:0
        '{1'b0,1'b0,1'b1,16'd5,16'h0200,16'h0020,4'h0,1'b1,1'b0}, // R3 A reacts to CB
        '{1'b0,1'b0,1'b1,16'd3,16'h0200,16'h0020,4'h0,1'b1,1'b1}  // R3 B reacts to CA
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // drive one cycle of stimulus after a falling edge, sample at the next
    task automatic cyc(input logic z, input logic p, input logic up, input int c);
        evt_zero = z; evt_period = p; cnt_up = up; tb_cnt = CNT_W'(c);
        @(negedge clk);
        cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    endtask

    task automatic duty_run(input logic [15:0] act, output int highs);
        highs = 0;
        act_cfg_a = act;
        for (int per = 0; per < 3; per++) begin
            for (int c = 0; c < 10; c++) begin
                cyc(c == 0, c == 9, 1'b1, c);
                if (per == 2 && pwm_a) highs++;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        int highs;
        @(negedge clk);
        chk("R1 reset level A", pwm_a, 1'b0);
        chk("R1 reset level B", pwm_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 0); // count 0 equals reset compare, actions none
        chk("R1 after release A", pwm_a, 1'b0);
        chk("R1 after release B", pwm_b, 1'b0);

        // load compare values immediately
        cmpa_wr = 1'b1; cmpa_val = 16'd3; cmpb_wr = 1'b1; cmpb_val = 16'd5;
        cyc(1'b0, 1'b0, 1'b0, 100);

        for (int i = 0; i < NVEC; i++) begin
            act_cfg_a = VEC[i].aa; act_cfg_b = VEC[i].ab; sw_force = VEC[i].frc;
            cyc(VEC[i].z, VEC[i].p, VEC[i].up, int'(VEC[i].cnt));
            chk($sformatf("table row %0d A", i), pwm_a, VEC[i].ea);
            chk($sformatf("table row %0d B", i), pwm_b, VEC[i].eb);
        end
        // state now A=1, B=1

        // R5: both compares at 7, CA high vs CB low on A
        act_cfg_a = 16'h0; act_cfg_b = 16'h0;
        cmpa_wr = 1'b1; cmpa_val = 16'd7; cmpb_wr = 1'b1; cmpb_val = 16'd7;
        cyc(1'b0, 1'b0, 1'b0, 100);
        act_cfg_a = 16'h0120;
        cyc(1'b0, 1'b0, 1'b1, 7);
        chk("R5 compare B outranks compare A", pwm_a, 1'b0);
        chk("R5 B untouched", pwm_b, 1'b1);

        // R6: immediate write used from the next cycle
        act_cfg_a = 16'h0020;
        cmpa_wr = 1'b1; cmpa_val = 16'd9;
        cyc(1'b0, 1'b0, 1'b1, 9);
        chk("R6 new value not yet active", pwm_a, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 9);
        chk("R6 new value active", pwm_a, 1'b1);

        // R7: shadow A, load at period
        cmp_cfg = 16'h0011; act_cfg_a = 16'h0010;
        cmpa_wr = 1'b1; cmpa_val = 16'd11;
        cyc(1'b0, 1'b0, 1'b1, 11);
        chk("R7 shadow write not active", pwm_a, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 11);
        chk("R7 no load without period", pwm_a, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 11);
        chk("R7 loaded at period", pwm_a, 1'b0);

        // R7: frozen select
        cmp_cfg = 16'h0013; act_cfg_a = 16'h0020;
        cmpa_wr = 1'b1; cmpa_val = 16'd13;
        cyc(1'b0, 1'b0, 1'b0, 100);
        cyc(1'b1, 1'b1, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 13);
        chk("R7 frozen keeps old compare", pwm_a, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 11);
        chk("R7 old compare still matches", pwm_a, 1'b1);

        // R7: load at zero only
        cmp_cfg = 16'h0010; act_cfg_a = 16'h0010;
        cyc(1'b0, 1'b1, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 13);
        chk("R7 zero select ignores period", pwm_a, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 13);
        chk("R7 zero select loads at zero", pwm_a, 1'b0);

        // R7: either select
        cmp_cfg = 16'h0012; act_cfg_a = 16'h0020;
        cmpa_wr = 1'b1; cmpa_val = 16'd15;
        cyc(1'b0, 1'b0, 1'b0, 100);
        cyc(1'b0, 1'b1, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 15);
        chk("R7 either select loads at period", pwm_a, 1'b1);

        // R7: compare B fields (mode bit 6, select bits 3:2 = period)
        cmp_cfg = 16'h0044; act_cfg_a = 16'h0; act_cfg_b = 16'h0100;
        cmpb_wr = 1'b1; cmpb_val = 16'd17;
        cyc(1'b0, 1'b0, 1'b0, 100);
        cyc(1'b0, 1'b0, 1'b1, 17);
        chk("R7 B shadow not active", pwm_b, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b1, 17);
        chk("R7 B loaded at period", pwm_b, 1'b0);

        // R9: duty over a period of ten counts
        cmp_cfg = 16'h0; act_cfg_b = 16'h0;
        cmpa_wr = 1'b1; cmpa_val = 16'd4;
        cyc(1'b0, 1'b0, 1'b0, 100);
        duty_run(16'h0012, highs);
        chk_int("R9 non-inverted duty 4", highs, 4);
        duty_run(16'h0021, highs);
        chk_int("R9 inverted duty 4", highs, 6);
        cmpa_wr = 1'b1; cmpa_val = 16'd0;
        cyc(1'b0, 1'b0, 1'b0, 100);
        duty_run(16'h0012, highs);
        chk_int("R9 non-inverted compare 0 constant low", highs, 0);
        duty_run(16'h0021, highs);
        chk_int("R9 inverted compare 0 constant high", highs, 10);

        finish_run();
    end

endmodule